// File: doc/BRIEF.md
# Windowed MAP Recursion Scheduler

This block sequences the three recursion engines of a serial, window-based soft-output decoder. A data block of `blk_len` symbols is cut into windows of `win_len` symbols. Each window passes through a three-step pipeline, and each step lasts exactly `win_len` cycles:

- In the first step its branch metrics are written into a scratch buffer, while a warm-up backward recursion runs over its first `acq_len` symbols.
- In the second step the forward engine reads that buffer in ascending order and stores its state metrics.
- In the third step the backward engine reads the buffer in descending order and emits one LLR per symbol, so LLRs leave each window last symbol first.

Three scratch buffers are used in rotation. Each buffer is written, then read forward, then read backward, so it is busy for three consecutive steps and is free to be written again in the fourth.

The block is started by a one-cycle `start` pulse. It latches the three lengths and drives the following:

- enables, buffer selects, window numbers and local addresses for every engine;
- the global index of each LLR produced;
- a flag telling the backward engine to start from the terminated trellis state on the final window.

After the last window has drained through the backward stage, `done` rises and stays high until the next start. The arithmetic of the engines is outside this block.

Top module: `swin_sched`

## Requirements
- R1: After reset `busy` and `done` are 0 and the enables `wr_en`, `acq_en`, `fwd_en` and `bwd_en` are all 0.
- R2: A `start` pulse while idle latches `blk_len`, `win_len` and `acq_len`, and `busy` is 1 from the next cycle on. A `start` pulse while `busy` is 1 is ignored and does not change the schedule.
- R3: In step s (counted from 0 after start, each step lasting `win_len` cycles), window s is written with `wr_sel` = s mod 3, `wr_win` = s and `wr_addr` running 0 up to `win_len`-1.
- R4: In step s, window s-1 is read by the forward engine with `fwd_sel` = (s-1) mod 3, `fwd_win` = s-1 and `fwd_addr` running 0 up to `win_len`-1.
- R5: In step s, window s-2 is processed by the backward engine with `bwd_sel` = (s-2) mod 3, `bwd_win` = s-2 and `bwd_addr` running `win_len`-1 down to 0. `llr_idx` equals (s-2)·`win_len` + `bwd_addr`.
- R6: Whenever two of `wr_en`, `fwd_en` and `bwd_en` are 1 in the same cycle, their buffer selects differ.
- R7: Acquisition runs on every window except window 0, during the first `acq_len` cycles of the window's write step. `acq_addr` runs `acq_len`-1 down to 0.
- R8: Any engine position whose global symbol index is `blk_len` or more has its enable held at 0, yet the step still lasts `win_len` cycles.
- R9: With W = ceil(`blk_len`/`win_len`) windows, `busy` stays 1 for exactly (W+2)·`win_len` cycles. `done` then becomes 1 and `busy` 0, and `done` holds until the next start.
- R10: `bwd_term` is 1 exactly when `bwd_en` is 1 on window W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start request |
| blk_len | input | LEN_W | Block length in symbols (at least 1) |
| win_len | input | WIN_W | Window length in symbols (at least 1) |
| acq_len | input | WIN_W | Acquisition length (at most `win_len`) |
| busy | output | 1 | Schedule running |
| done | output | 1 | Schedule finished, held until next start |
| wr_en | output | 1 | Branch-metric buffer write strobe |
| wr_sel | output | 2 | Buffer written (0..2) |
| wr_addr | output | WIN_W | Local write address |
| wr_win | output | LEN_W | Window being written |
| acq_en | output | 1 | Acquisition engine enable |
| acq_addr | output | WIN_W | Local acquisition address |
| fwd_en | output | 1 | Forward engine enable |
| fwd_sel | output | 2 | Buffer read by forward engine |
| fwd_addr | output | WIN_W | Local forward address (also state-metric store address) |
| fwd_win | output | LEN_W | Window in forward recursion |
| bwd_en | output | 1 | Backward/LLR engine enable |
| bwd_sel | output | 2 | Buffer read by backward engine |
| bwd_addr | output | WIN_W | Local backward address (also state-metric load address) |
| bwd_win | output | LEN_W | Window in backward recursion |
| bwd_term | output | 1 | Backward recursion starts from terminated state |
| llr_idx | output | LEN_W | Global index of the LLR produced |

## Verification
The central hazard is that a buffer is written for a new window in the same cycle as the other two buffers are being read forward and backward. A stale or slipped select would let a write overwrite metrics that the backward engine still needs. Runs of four or more windows keep all three engines active together for several steps, and every such cycle is compared with the expected selects and addresses. The same runs check that the three active selects never coincide. A short final window also puts masked positions in the same cycles as live reads of the previous windows, which shows that the masking cuts only the engine it belongs to.

// File: rtl/swin_sched.sv
module swin_sched #(
  parameter int LEN_W = 10,
  parameter int WIN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [WIN_W-1:0] win_len,
  input  logic [WIN_W-1:0] acq_len,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [1:0]       wr_sel,
  output logic [WIN_W-1:0] wr_addr,
  output logic [LEN_W-1:0] wr_win,
  output logic             acq_en,
  output logic [WIN_W-1:0] acq_addr,
  output logic             fwd_en,
  output logic [1:0]       fwd_sel,
  output logic [WIN_W-1:0] fwd_addr,
  output logic [LEN_W-1:0] fwd_win,
  output logic             bwd_en,
  output logic [1:0]       bwd_sel,
  output logic [WIN_W-1:0] bwd_addr,
  output logic [LEN_W-1:0] bwd_win,
  output logic             bwd_term,
  output logic [LEN_W-1:0] llr_idx
);
  localparam int BW = LEN_W + 1;

  logic [LEN_W-1:0] len_q;
  logic [WIN_W-1:0] wl_q, al_q, cnt;
  logic             busy_q, done_q;
  logic [BW-1:0]    base_w, base_f, base_b;
  logic             vld_w, vld_f, vld_b;
  logic [1:0]       sel_w, sel_f, sel_b;
  logic [LEN_W-1:0] win_w, win_f, win_b;

  logic             step_end;
  logic [BW-1:0]    len_x, wl_x, cnt_x, base_nxt;
  logic [WIN_W-1:0] rev, acq_off;

  assign step_end = busy_q && (cnt == wl_q - 1'b1);
  assign len_x    = BW'(len_q);
  assign wl_x     = BW'(wl_q);
  assign cnt_x    = BW'(cnt);
  assign base_nxt = base_w + wl_x;
  assign rev      = wl_q - 1'b1 - cnt;
  assign acq_off  = al_q - 1'b1 - cnt;

  assign busy     = busy_q;
  assign done     = done_q;

  assign wr_en    = busy_q && vld_w && (base_w + cnt_x < len_x);
  assign wr_sel   = sel_w;
  assign wr_addr  = cnt;
  assign wr_win   = win_w;

  assign acq_en   = busy_q && vld_w && (win_w != '0) && (cnt < al_q) &&
                    (base_w + BW'(acq_off) < len_x);
  assign acq_addr = acq_off;

  assign fwd_en   = busy_q && vld_f && (base_f + cnt_x < len_x);
  assign fwd_sel  = sel_f;
  assign fwd_addr = cnt;
  assign fwd_win  = win_f;

  assign bwd_en   = busy_q && vld_b && (base_b + BW'(rev) < len_x);
  assign bwd_sel  = sel_b;
  assign bwd_addr = rev;
  assign bwd_win  = win_b;
  assign bwd_term = bwd_en && (base_b + wl_x >= len_x);
  assign llr_idx  = LEN_W'(base_b + BW'(rev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      wl_q   <= '0;
      al_q   <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      base_w <= '0;
      base_f <= '0;
      base_b <= '0;
      vld_w  <= 1'b0;
      vld_f  <= 1'b0;
      vld_b  <= 1'b0;
      sel_w  <= 2'd0;
      sel_f  <= 2'd0;
      sel_b  <= 2'd0;
      win_w  <= '0;
      win_f  <= '0;
      win_b  <= '0;
    end else if (start && !busy_q) begin
      len_q  <= blk_len;
      wl_q   <= win_len;
      al_q   <= acq_len;
      cnt    <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      base_w <= '0;
      vld_w  <= 1'b1;
      vld_f  <= 1'b0;
      vld_b  <= 1'b0;
      sel_w  <= 2'd0;
      win_w  <= '0;
    end else if (busy_q) begin
      cnt <= step_end ? '0 : cnt + 1'b1;
      if (step_end) begin
        base_f <= base_w;
        base_b <= base_f;
        vld_f  <= vld_w;
        vld_b  <= vld_f;
        sel_f  <= sel_w;
        sel_b  <= sel_f;
        win_f  <= win_w;
        win_b  <= win_f;
        base_w <= base_nxt;
        vld_w  <= vld_w && (base_nxt < len_x);
        sel_w  <= (sel_w == 2'd2) ? 2'd0 : sel_w + 2'd1;
        win_w  <= win_w + 1'b1;
        if (!vld_w && !vld_f) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          vld_b  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/swin_sched_chk.sv
module swin_sched_chk #(
  parameter int WIN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             acq_en,
  input logic             fwd_en,
  input logic [1:0]       fwd_sel,
  input logic [WIN_W-1:0] fwd_addr,
  input logic             bwd_en,
  input logic [1:0]       bwd_sel,
  input logic [WIN_W-1:0] bwd_addr,
  input logic             bwd_term
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en && !acq_en && !fwd_en && !bwd_en);

  assert_fwd_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en && fwd_addr != '0 |-> $past(fwd_en) && ($past(fwd_addr) == fwd_addr - 1'b1));

  assert_bwd_descending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bwd_en && $past(bwd_en) && $past(bwd_addr) != '0 |-> bwd_addr == $past(bwd_addr) - 1'b1);

  assert_sel_wr_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && fwd_en |-> wr_sel != fwd_sel);

  assert_sel_wr_bwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bwd_en |-> wr_sel != bwd_sel);

  assert_sel_fwd_bwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en && bwd_en |-> fwd_sel != bwd_sel);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_term_in_bwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bwd_term |-> bwd_en);
endmodule

bind swin_sched swin_sched_chk #(.WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_sel(wr_sel), .acq_en(acq_en),
  .fwd_en(fwd_en), .fwd_sel(fwd_sel), .fwd_addr(fwd_addr),
  .bwd_en(bwd_en), .bwd_sel(bwd_sel), .bwd_addr(bwd_addr),
  .bwd_term(bwd_term)
);

// File: tb/swin_sched_test.sv
module swin_sched_test;
  localparam int LEN_W = 10;
  localparam int WIN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [WIN_W-1:0] win_len = '0, acq_len = '0;
  logic busy, done, wr_en, acq_en, fwd_en, bwd_en, bwd_term;
  logic [1:0] wr_sel, fwd_sel, bwd_sel;
  logic [WIN_W-1:0] wr_addr, acq_addr, fwd_addr, bwd_addr;
  logic [LEN_W-1:0] wr_win, fwd_win, bwd_win, llr_idx;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  swin_sched #(.LEN_W(LEN_W), .WIN_W(WIN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .win_len(win_len), .acq_len(acq_len), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_win(wr_win),
    .acq_en(acq_en), .acq_addr(acq_addr),
    .fwd_en(fwd_en), .fwd_sel(fwd_sel), .fwd_addr(fwd_addr), .fwd_win(fwd_win),
    .bwd_en(bwd_en), .bwd_sel(bwd_sel), .bwd_addr(bwd_addr), .bwd_win(bwd_win),
    .bwd_term(bwd_term), .llr_idx(llr_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk({wr_en, acq_en, fwd_en, bwd_en} == 4'b0, "R1 enables", {wr_en, acq_en, fwd_en, bwd_en}, 0);
  endtask

  task automatic run_case(input int L, input int WL, input int AL, input int restart_at);
    int nw, tot;
    nw = (L + WL - 1) / WL;
    tot = (nw + 2) * WL;
    blk_len = LEN_W'(L);
    win_len = WIN_W'(WL);
    acq_len = WIN_W'(AL);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blk_len = '1;
    win_len = 6'd3;
    acq_len = 6'd1;
    for (int t = 0; t < tot; t++) begin
      int s, c, w, a;
      bit e;
      s = t / WL;
      c = t % WL;
      if (t == restart_at) start = 1'b1;
      else start = 1'b0;
      chk(busy == 1'b1, "R9 busy during run", busy, 1);
      w = s;
      e = (w < nw) && (w * WL + c < L);
      chk(wr_en == e, "R3/R8 wr_en", wr_en, e);
      if (e) begin
        chk(wr_sel == 2'(s % 3), "R3/R6 wr_sel", wr_sel, s % 3);
        chk(wr_addr == WIN_W'(c), "R3 wr_addr", wr_addr, c);
        chk(wr_win == LEN_W'(w), "R3 wr_win", wr_win, w);
      end
      a = AL - 1 - c;
      e = (w >= 1) && (w < nw) && (c < AL) && (w * WL + a < L);
      chk(acq_en == e, "R7/R8 acq_en", acq_en, e);
      if (e) chk(acq_addr == WIN_W'(a), "R7 acq_addr", acq_addr, a);
      w = s - 1;
      e = (w >= 0) && (w < nw) && (w * WL + c < L);
      chk(fwd_en == e, "R4/R8 fwd_en", fwd_en, e);
      if (e) begin
        chk(fwd_sel == 2'(w % 3), "R4/R6 fwd_sel", fwd_sel, w % 3);
        chk(fwd_addr == WIN_W'(c), "R4 fwd_addr", fwd_addr, c);
        chk(fwd_win == LEN_W'(w), "R4 fwd_win", fwd_win, w);
      end
      w = s - 2;
      a = WL - 1 - c;
      e = (w >= 0) && (w < nw) && (w * WL + a < L);
      chk(bwd_en == e, "R5/R8 bwd_en", bwd_en, e);
      chk(bwd_term == (e && w == nw - 1), "R10 bwd_term", bwd_term, e && w == nw - 1);
      if (e) begin
        chk(bwd_sel == 2'(w % 3), "R5/R6 bwd_sel", bwd_sel, w % 3);
        chk(bwd_addr == WIN_W'(a), "R5 bwd_addr", bwd_addr, a);
        chk(bwd_win == LEN_W'(w), "R5 bwd_win", bwd_win, w);
        chk(llr_idx == LEN_W'(w * WL + a), "R5 llr_idx", llr_idx, w * WL + a);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy == 1'b0, "R9 busy end", busy, 0);
    chk(done == 1'b1, "R9 done end", done, 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R9 done held", done, 1);
  endtask

  task automatic test_full_windows();   run_case(32, 8, 4, -1); endtask
  task automatic test_short_tail();     run_case(29, 8, 6, -1); endtask
  task automatic test_single_window();  run_case(5, 8, 3, -1);  endtask
  task automatic test_acq_eq_window();  run_case(20, 4, 4, -1); endtask
  task automatic test_restart_ignored_r2(); run_case(45, 7, 5, 13); endtask
  task automatic test_tail_one_symbol(); run_case(17, 8, 8, -1); endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_full_windows();
        test_short_tail();
        test_single_window();
        test_acq_eq_window();
        test_restart_ignored_r2();
        test_tail_one_symbol();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule